// File: doc/BRIEF.md
# Interval-Sampling Event Counter

This block counts single-cycle increment strobes and samples the running count at a programmable interval. A divider running on the system clock produces an interval tick once every (1 + divider setting) cycles. On each tick the current count is copied into a last-sample register and appended to a small sample queue, and an interval event is flagged. If clear-on-tick is selected, the count restarts from zero after each capture.

The divider setting and the two mode bits come from register-style inputs. The divider phase restarts whenever the divider setting is written. A consumer drains the queue through a pop strobe. The queue's current fill and its fixed capacity are both visible on the ports. A sticky flag records any sample that was lost because the queue was full.

Top module: `interval_sampler`

## Requirements
- R1: While reset is held and in the cycle after it, the count, the last sample, the queue fill, the read data, the overflow flag and both event outputs are 0, and `fifo_cap_o` equals the DEPTH parameter.
- R2: With ticks enabled and the divider setting N left unwritten, interval ticks recur every 1 + N cycles, so N = 0 gives a tick on every cycle.
- R3: While `mode_i[0]` (tick enable) is 0, no tick occurs, and neither the last sample nor the queue changes because of ticks.
- R4: On each tick, the count held before that clock edge is loaded into `last_o` and pushed into the queue, and both carry the same value.
- R5: `tick_evt_o` is high for exactly the cycle in which `last_o` shows the sample of that tick.
- R6: With `mode_i[1]` (clear-on-tick) set, a tick leaves the count at 0, or at 1 when an increment strobe arrives in the same cycle. The capture still sees the old count.
- R7: `cnt_chg_o` is high for one cycle whenever `count_o` has just taken a value different from its previous one. A clear from a nonzero count and a wrap to zero both count as changes.
- R8: A tick that finds the queue holding DEPTH samples stores nothing and sets `ovf_o`, which stays set until reset.
- R9: A pop while the queue is empty leaves `fifo_data_o` unchanged. A pop on a non-empty queue shows the oldest sample on `fifo_data_o` one cycle later.
- R10: Pulsing `div_wr_i` with a new setting N restarts the divider, and the first tick after that comes 1 + N cycles after the write cycle.
- R11: `fifo_level_o` reports the number of samples held, which is never more than DEPTH.
- R12: Each increment strobe raises the count by one, modulo 2^CNT_W, when no clear-on-tick applies.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inc_i | input | 1 | Increment strobe |
| div_val_i | input | DIV_W | Divider setting N (tick every 1 + N cycles) |
| div_wr_i | input | 1 | Divider write strobe; restarts the divider phase |
| mode_i | input | 2 | Bit 0 enables ticks; bit 1 selects clear-on-tick |
| pop_i | input | 1 | Remove the oldest sample from the queue |
| count_o | output | CNT_W | Running count |
| last_o | output | CNT_W | Count captured at the most recent tick |
| tick_evt_o | output | 1 | Interval event, aligned with the `last_o` update |
| cnt_chg_o | output | 1 | Count-changed event |
| fifo_data_o | output | CNT_W | Sample read by the most recent successful pop |
| fifo_level_o | output | $clog2(DEPTH+1) | Samples currently queued |
| fifo_cap_o | output | $clog2(DEPTH+1) | Queue capacity (DEPTH) |
| ovf_o | output | 1 | Sticky flag: a sample was dropped |

## Verification
The hardest situations to reach are the ones where several things land on one tick: a full queue with a pop in the same cycle, an increment on a clearing tick, and a divider write in the cycle where a tick was due. Directed phases fill the queue without popping, drain it past empty, and time a divider write. A long random phase then varies the increment, pop and mode inputs and rewrites the divider often, using small settings so that ticks stay dense. A narrow count width lets wraps happen within the run.

// File: rtl/isc_pkg.sv
package isc_pkg;
  typedef struct packed {
    logic clr_on_tick;
    logic tick_en;
  } isc_mode_t;

  function automatic int unsigned isc_lvl_w(input int unsigned depth);
    return $clog2(depth + 1);
  endfunction
endpackage

// File: rtl/isc_divider.sv
module isc_divider #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_val_i,
  input  logic             div_wr_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] phase_q;

  function automatic logic phase_done(input logic [DIV_W-1:0] ph,
                                      input logic [DIV_W-1:0] lim);
    return ph >= lim;
  endfunction

  assign tick_o = en_i && !div_wr_i && phase_done(phase_q, div_val_i);

  always_ff @(posedge clk) begin
    if (!rst_n)               phase_q <= '0;
    else if (!en_i || div_wr_i || tick_o) phase_q <= '0;
    else                      phase_q <= phase_q + 1'b1;
  end

  AST_WR_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    div_wr_i |=> (phase_q == '0)) else $error("divider phase"); // R10
endmodule

// File: rtl/isc_counter.sv
module isc_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_i,
  input  logic             tick_i,
  input  logic             clr_on_tick_i,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] last_o,
  output logic             tick_evt_o,
  output logic             cnt_chg_o
);
  logic [CNT_W-1:0] count_q, last_q, count_d;
  logic             evt_q, chg_q;

  function automatic logic [CNT_W-1:0] next_count(input logic [CNT_W-1:0] c,
                                                  input logic inc,
                                                  input logic clr_now);
    if (clr_now) return inc ? CNT_W'(1) : '0;
    return c + CNT_W'(inc);
  endfunction

  assign count_d = next_count(count_q, inc_i, tick_i && clr_on_tick_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q <= '0;
      last_q  <= '0;
      evt_q   <= 1'b0;
      chg_q   <= 1'b0;
    end else begin
      count_q <= count_d;
      chg_q   <= (count_d != count_q);
      evt_q   <= tick_i;
      if (tick_i) last_q <= count_q;
    end
  end

  assign count_o    = count_q;
  assign last_o     = last_q;
  assign tick_evt_o = evt_q;
  assign cnt_chg_o  = chg_q;

  AST_CLR_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && clr_on_tick_i && !inc_i) |=> (count_q == '0)) else $error("clear"); // R6
  AST_CHG_MEANS_NEW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_chg_o |-> (count_q != $past(count_q))) else $error("chg"); // R7
  AST_LAST_IS_OLD_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i |=> (last_q == $past(count_q))) else $error("last"); // R4
endmodule

// File: rtl/isc_fifo.sv
module isc_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 8,
  localparam int LVL_W = $clog2(DEPTH + 1),
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic [W-1:0]     push_data_i,
  input  logic             pop_i,
  output logic [W-1:0]     pop_data_o,
  output logic [LVL_W-1:0] level_o,
  output logic             ovf_o
);
  logic [W-1:0]     mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [LVL_W-1:0] level_q;
  logic [W-1:0]     dout_q;
  logic             ovf_q;
  logic             full, empty, do_wr, do_rd;

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full  = (level_q == LVL_W'(DEPTH));
  assign empty = (level_q == '0);
  assign do_wr = push_i && !full;
  assign do_rd = pop_i && !empty;

  always_ff @(posedge clk) begin
    if (do_wr) mem[wr_ptr] <= push_data_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      level_q <= '0;
      dout_q  <= '0;
      ovf_q   <= 1'b0;
    end else begin
      if (do_wr) wr_ptr <= ptr_next(wr_ptr);
      if (do_rd) begin
        rd_ptr <= ptr_next(rd_ptr);
        dout_q <= mem[rd_ptr];
      end
      level_q <= level_q + LVL_W'(do_wr) - LVL_W'(do_rd);
      if (push_i && full) ovf_q <= 1'b1;
    end
  end

  assign pop_data_o = dout_q;
  assign level_o    = level_q;
  assign ovf_o      = ovf_q;

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    level_q <= LVL_W'(DEPTH)) else $error("level"); // R11
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |=> ovf_q) else $error("ovf"); // R8
  AST_POP_EMPTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && empty) |=> $stable(dout_q)) else $error("pop empty"); // R9
endmodule

// File: rtl/interval_sampler.sv
module interval_sampler #(
  parameter int CNT_W = 16,
  parameter int DIV_W = 16,
  parameter int DEPTH = 8,
  localparam int LVL_W = isc_pkg::isc_lvl_w(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_i,
  input  logic [DIV_W-1:0] div_val_i,
  input  logic             div_wr_i,
  input  logic [1:0]       mode_i,
  input  logic             pop_i,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] last_o,
  output logic             tick_evt_o,
  output logic             cnt_chg_o,
  output logic [CNT_W-1:0] fifo_data_o,
  output logic [LVL_W-1:0] fifo_level_o,
  output logic [LVL_W-1:0] fifo_cap_o,
  output logic             ovf_o
);
  isc_pkg::isc_mode_t mode;
  logic               tick;

  assign mode = isc_pkg::isc_mode_t'(mode_i);

  isc_divider #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .en_i(mode.tick_en),
    .div_val_i(div_val_i), .div_wr_i(div_wr_i), .tick_o(tick)
  );

  isc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .inc_i(inc_i), .tick_i(tick),
    .clr_on_tick_i(mode.clr_on_tick), .count_o(count_o), .last_o(last_o),
    .tick_evt_o(tick_evt_o), .cnt_chg_o(cnt_chg_o)
  );

  isc_fifo #(.W(CNT_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push_i(tick), .push_data_i(count_o),
    .pop_i(pop_i), .pop_data_o(fifo_data_o), .level_o(fifo_level_o),
    .ovf_o(ovf_o)
  );

  assign fifo_cap_o = LVL_W'(DEPTH);

  AST_NO_TICK_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_i[0] |=> !tick_evt_o) else $error("tick while off"); // R3
  AST_EVT_WITH_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (tick_evt_o && last_o == $past(count_o))) else $error("evt"); // R5
endmodule

// File: tb/test_interval_sampler.sv
module test_interval_sampler;
  localparam int CW = 6, DW = 8, D = 8, LW = $clog2(D + 1);
  localparam int MASK = (1 << CW) - 1;

  logic clk = 0, rst_n = 0, inc = 0, dwr = 0, pop = 0;
  logic [DW-1:0] dval = '0;
  logic [1:0] mode = 2'b00;
  logic [CW-1:0] count, last, dout;
  logic evt, chg, ovf;
  logic [LW-1:0] lvl, cap;

  int checks = 0, fails = 0;
  bit done = 0;

  interval_sampler #(.CNT_W(CW), .DIV_W(DW), .DEPTH(D)) i_interval_sampler (
    .clk(clk), .rst_n(rst_n), .inc_i(inc), .div_val_i(dval), .div_wr_i(dwr),
    .mode_i(mode), .pop_i(pop), .count_o(count), .last_o(last),
    .tick_evt_o(evt), .cnt_chg_o(chg), .fifo_data_o(dout),
    .fifo_level_o(lvl), .fifo_cap_o(cap), .ovf_o(ovf)
  );

  always #5 clk = ~clk;

  // independent reference model
  int m_cnt, m_last, m_dout, m_ph;
  bit m_evt, m_chg, m_ovf;
  int q[$];

  function automatic bit m_tick_now();
    return mode[0] && !dwr && (m_ph >= int'(dval));
  endfunction

  function automatic int m_next(int c, bit tk);
    if (tk && mode[1]) return inc ? 1 : 0;
    return (c + (inc ? 1 : 0)) & MASK;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_last = 0; m_dout = 0; m_ph = 0;
      m_evt = 0; m_chg = 0; m_ovf = 0; q.delete();
    end else begin
      bit tk; int nx; bit was_full, was_empty;
      tk = m_tick_now();
      nx = m_next(m_cnt, tk);
      was_full  = (q.size() >= D);
      was_empty = (q.size() == 0);
      if (pop && !was_empty) m_dout = q.pop_front();
      if (tk) begin
        if (was_full) m_ovf = 1; else q.push_back(m_cnt);
        m_last = m_cnt;
      end
      m_evt = tk;
      m_chg = (nx != m_cnt);
      m_cnt = nx;
      if (!mode[0] || dwr || tk) m_ph = 0; else m_ph++;
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // lockstep comparison, sampled 2 ns after each rising edge
  always @(posedge clk) begin
    #2;
    if (rst_n && !done) begin
      chk("R12/R6 count", count, m_cnt);
      chk("R4 last", last, m_last);
      chk("R5/R2 tick_evt", evt, m_evt);
      chk("R7 cnt_chg", chg, m_chg);
      chk("R9/R4 fifo_data", dout, m_dout);
      chk("R11 level", lvl, q.size());
      chk("R8 ovf", ovf, m_ovf);
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #1_500_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int n;
    void'($urandom(32'd4711));
    cyc(3);
    // R1: reset state
    chk("R1 count", count, 0); chk("R1 last", last, 0); chk("R1 level", lvl, 0);
    chk("R1 dout", dout, 0); chk("R1 ovf", ovf, 0); chk("R1 evt", evt, 0);
    chk("R1 chg", chg, 0); chk("R1 cap", cap, D);
    rst_n = 1;
    cyc(1);
    chk("R1 count after release", count, 0);

    // R3: disabled, increments only
    mode = 2'b00; inc = 1;
    cyc(20);
    inc = 0;
    cyc(1);
    chk("R3 level stays empty", lvl, 0);
    chk("R3 last unchanged", last, 0);
    chk("R12 count after 20 strobes", count, 20);

    // R2: N=0 tick every cycle, fill FIFO -> R8 overflow
    dval = 0; dwr = 1; cyc(1); dwr = 0;
    mode = 2'b01;
    cyc(12);
    chk("R8 full level", lvl, D);
    chk("R8 overflow set", ovf, 1);
    mode = 2'b00;
    // R9: drain past empty
    pop = 1; cyc(D + 4); pop = 0;
    cyc(1);
    chk("R9 drained level", lvl, 0);
    chk("R9 data held after empty pops", dout, 20);

    // R10: write N=5, first event 6 edges later
    mode = 2'b01; dval = 5; dwr = 1;
    @(posedge clk); @(negedge clk); dwr = 0;
    n = 0;
    do begin
      @(posedge clk); #2; n++;
    end while (!evt && n < 40);
    chk("R10 cycles to first tick", n, 6);
    // R2: next period 6
    n = 0;
    do begin
      @(posedge clk); #2; n++;
    end while (!evt && n < 40);
    chk("R2 period for N=5", n, 6);

    // R6: clear on tick with increments
    @(negedge clk);
    mode = 2'b11; inc = 1; pop = 1;
    cyc(30);
    inc = 0; pop = 0;

    // random phase
    for (int i = 0; i < 4000; i++) begin
      inc = ($urandom % 2) == 0;
      pop = ($urandom % 4) == 0;
      dwr = ($urandom % 25) == 0;
      if (dwr) dval = DW'($urandom % 6);
      if (($urandom % 60) == 0) mode = 2'($urandom);
      cyc(1);
    end
    inc = 0; pop = 0; dwr = 0;
    cyc(3);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule